// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests from a parameterized group of peripheral sources and from a few CPU-internal events. It ranks them and, when the CPU strobes a vector fetch, returns the 16-bit address of the table entry that belongs to the winning request. The table base is relocatable: an 8-bit base register supplies the upper address byte, and each request class has a fixed low byte. While debug freeze is active, the base is forced to 0xFF. Three system reset vectors sit at fixed addresses that the base never moves.

The CPU's I and X mask bits are inputs. Clearing the I mask inside a handler makes the I-maskable group eligible again, which is how nesting works. A pending line reports any unmasked request. In stop or wait mode the clock is off, so a wake-up line is formed combinationally from the request and mask inputs.

A small state machine runs the fetch. It has three states. `ST_IDLE` drives no vector. `ST_IRQV` drives a latched interrupt vector for one cycle. `ST_RSTV` drives a latched reset vector for one cycle. The transitions are:

- `GO_IRQ`: on `vec_req` without `rst_req`, from any state to `ST_IRQV`.
- `GO_RST`: on `rst_req`, from any state to `ST_RSTV`.
- `DONE`: with no strobe, back to `ST_IDLE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The base register resets to 0xFF. A write (`base_wr` high at a clock edge) loads `base_wdata`. Every interrupt vector has the effective base as its upper byte.
- R2: I-maskable source k (bit k of `i_req`) has vector base:(0xF2 − 2·k). When several are pending, the lowest index wins, which is the highest address.
- R3: The fixed priority is trap (low byte 0xF8), then software/debug (0xF6), then X-maskable (0xF4), then the I-maskable group.
- R4: `i_mask` high suppresses every I-maskable source, and `x_mask` high suppresses the X-maskable source. Trap and software/debug requests cannot be masked.
- R5: A fetch with no unmasked request returns base:0x80.
- R6: A strobe sampled at clock edge N sets `vec_valid` and the vector on `vec_addr` for the single cycle after edge N. At all other times `vec_valid` is low and `vec_addr` is 0x0000.
- R7: On a reset-vector fetch (`rst_req`), `rst_src` 0 gives 0xFFFE, 1 gives 0xFFFC, 2 gives 0xFFFA and 3 gives 0xFFFE. The base and freeze have no effect on it, and it wins over a `vec_req` in the same cycle.
- R8: While `freeze` is high, interrupt vectors use base 0xFF. The programmed base is kept and applies again once freeze drops.
- R9: `irq_pend` is high, combinationally, exactly when some unmasked request is present.
- R10: `wake` is high, combinationally, only in stop or wait mode and only when an unmasked X-maskable or I-maskable request is present. Trap and software requests do not wake the block.
- R11: The returned vector reflects requests and masks at the strobe edge. Changing them afterwards does not alter the vector being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | NUM_I | I-maskable request lines, bit 0 highest priority |
| i_mask | input | 1 | CPU I mask bit |
| x_req | input | 1 | X-maskable request |
| x_mask | input | 1 | CPU X mask bit |
| swi_req | input | 1 | Software interrupt or debug request |
| trap_req | input | 1 | Unimplemented op-code trap |
| stop_mode | input | 1 | Stop mode active |
| wait_mode | input | 1 | Wait mode active |
| freeze | input | 1 | Debug freeze active |
| base_wr | input | 1 | Base register write enable |
| base_wdata | input | 8 | Base register write data (upper address byte) |
| vec_req | input | 1 | Interrupt vector fetch strobe |
| rst_req | input | 1 | Reset vector fetch strobe |
| rst_src | input | 2 | Reset vector selector |
| vec_addr | output | 16 | Vector address, zero when not valid |
| vec_valid | output | 1 | Vector address valid |
| irq_pend | output | 1 | Unmasked request pending |
| wake | output | 1 | Wake-up request in a low-power mode |

## Verification
The vector is registered, so a strobe driven before edge N is checked at the falling edge after N. It is checked again one cycle later, when `vec_valid` and `vec_addr` must have returned to idle. `irq_pend` and `wake` are combinational: they are checked 1 ns after their inputs change, with no clock edge in between. A base write takes effect at its edge and is only observed through the next fetch. The sweeps cover every single source and every pair of sources under several bases, all 16 class combinations, all mask combinations and all mode and source combinations for wake-up.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQV = 2'd1,
        ST_RSTV = 2'd2
    } fsm_state_t;

    typedef enum logic [2:0] {
        CL_NONE = 3'd0,
        CL_TRAP = 3'd1,
        CL_SWI  = 3'd2,
        CL_XIRQ = 3'd3,
        CL_IIRQ = 3'd4
    } vec_class_t;

    localparam logic [7:0] OFF_TRAP   = 8'hF8;
    localparam logic [7:0] OFF_SWI    = 8'hF6;
    localparam logic [7:0] OFF_XIRQ   = 8'hF4;
    localparam logic [7:0] OFF_I_TOP  = 8'hF2;
    localparam logic [7:0] OFF_SPUR   = 8'h80;
    localparam logic [7:0] BASE_RESET = 8'hFF;
    localparam logic [7:0] BASE_DEBUG = 8'hFF;

    function automatic logic [7:0] class_offset(input vec_class_t cls,
                                                input logic [7:0] i_off);
        logic [7:0] r;
        unique case (cls)
            CL_TRAP: r = OFF_TRAP;
            CL_SWI:  r = OFF_SWI;
            CL_XIRQ: r = OFF_XIRQ;
            CL_IIRQ: r = i_off;
            default: r = OFF_SPUR;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] reset_vector(input logic [1:0] sel);
        logic [15:0] r;
        unique case (sel)
            2'd1:    r = 16'hFFFC;
            2'd2:    r = 16'hFFFA;
            default: r = 16'hFFFE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqv_base_reg.sv
module irqv_base_reg
    import irqv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_wr,
    input  logic [7:0] base_wdata,
    input  logic       freeze,
    output logic [7:0] base_eff
);

    logic [7:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       base_q <= BASE_RESET;
        else if (base_wr) base_q <= base_wdata;
    end

    always_comb begin
        base_eff = freeze ? BASE_DEBUG : base_q;
    end

    AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> base_q == $past(base_wdata)); // R1

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> $stable(base_q)); // R8

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_I-1:0] i_req,
    input  logic             i_mask,
    input  logic             x_req,
    input  logic             x_mask,
    input  logic             swi_req,
    input  logic             trap_req,
    output vec_class_t       win_cls,
    output logic [7:0]       win_off,
    output logic             pending,
    output logic             wake_src
);

    logic [NUM_I-1:0] i_eff;
    logic [NUM_I:0]   seen;
    logic [NUM_I-1:0] grant;
    logic [7:0]       i_off;
    logic             x_eff;
    logic             i_any;

    assign i_eff   = i_mask ? '0 : i_req;
    assign x_eff   = x_req & ~x_mask;
    assign seen[0] = 1'b0;

    for (genvar k = 0; k < NUM_I; k++) begin : g_chain
        assign seen[k+1] = seen[k] | i_eff[k];
        assign grant[k]  = i_eff[k] & ~seen[k];
    end

    assign i_any = seen[NUM_I];

    always_comb begin
        i_off = '0;
        for (int k = 0; k < NUM_I; k++) begin
            if (grant[k]) i_off = i_off | (OFF_I_TOP - 8'(2 * k));
        end
    end

    always_comb begin
        if (trap_req)     win_cls = CL_TRAP;
        else if (swi_req) win_cls = CL_SWI;
        else if (x_eff)   win_cls = CL_XIRQ;
        else if (i_any)   win_cls = CL_IIRQ;
        else              win_cls = CL_NONE;
        win_off  = class_offset(win_cls, i_off);
        pending  = (win_cls != CL_NONE);
        wake_src = x_eff | i_any;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (i_mask && x_mask && !swi_req && !trap_req) |-> !pending); // R4

    AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> win_off == OFF_TRAP); // R3

endmodule

// File: rtl/irqv_fetch_fsm.sv
module irqv_fetch_fsm
    import irqv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_req,
    input  logic        rst_req,
    input  logic [1:0]  rst_src,
    input  logic [7:0]  base_eff,
    input  logic [7:0]  win_off,
    output logic [15:0] vec_addr,
    output logic        vec_valid
);

    fsm_state_t state_q, state_d;
    logic [15:0] addr_q, addr_d;

    always_comb begin
        state_d = ST_IDLE;
        addr_d  = addr_q;
        if (rst_req) begin
            state_d = ST_RSTV;
            addr_d  = reset_vector(rst_src);
        end else if (vec_req) begin
            state_d = ST_IRQV;
            addr_d  = {base_eff, win_off};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IRQV, ST_RSTV: begin
                vec_valid = 1'b1;
                vec_addr  = addr_q;
            end
            default: begin
                vec_valid = 1'b0;
                vec_addr  = '0;
            end
        endcase
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req || rst_req) |=> vec_valid); // R6

    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_req || rst_req) |=> !vec_valid); // R6

    AST_RST_VEC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> vec_addr[15:3] == 13'h1FFF); // R7

    AST_VEC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !rst_req) |=> vec_addr[7:0] == $past(win_off)); // R11

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_I-1:0] i_req,
    input  logic             i_mask,
    input  logic             x_req,
    input  logic             x_mask,
    input  logic             swi_req,
    input  logic             trap_req,
    input  logic             stop_mode,
    input  logic             wait_mode,
    input  logic             freeze,
    input  logic             base_wr,
    input  logic [7:0]       base_wdata,
    input  logic             vec_req,
    input  logic             rst_req,
    input  logic [1:0]       rst_src,
    output logic [15:0]      vec_addr,
    output logic             vec_valid,
    output logic             irq_pend,
    output logic             wake
);

    logic [7:0] base_eff;
    logic [7:0] win_off;
    vec_class_t win_cls;
    logic       wake_src;
    logic       low_power;

    irqv_base_reg u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .freeze     (freeze),
        .base_eff   (base_eff)
    );

    irqv_arbiter #(.NUM_I(NUM_I)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_req    (i_req),
        .i_mask   (i_mask),
        .x_req    (x_req),
        .x_mask   (x_mask),
        .swi_req  (swi_req),
        .trap_req (trap_req),
        .win_cls  (win_cls),
        .win_off  (win_off),
        .pending  (irq_pend),
        .wake_src (wake_src)
    );

    irqv_fetch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_req   (vec_req),
        .rst_req   (rst_req),
        .rst_src   (rst_src),
        .base_eff  (base_eff),
        .win_off   (win_off),
        .vec_addr  (vec_addr),
        .vec_valid (vec_valid)
    );

    assign low_power = stop_mode | wait_mode;
    assign wake      = low_power & wake_src;

    AST_WAKE_NEEDS_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (stop_mode || wait_mode)); // R10

    AST_FREEZE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && vec_req && !rst_req) |=> vec_addr[15:8] == 8'hFF); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == 16'h0000); // R6

    AST_NONE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cls == CL_NONE) |-> !irq_pend); // R5

endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0] i_req = '0;
    logic i_mask = 1'b0, x_req = 1'b0, x_mask = 1'b0, swi_req = 1'b0, trap_req = 1'b0;
    logic stop_mode = 1'b0, wait_mode = 1'b0, freeze = 1'b0, base_wr = 1'b0;
    logic [7:0] base_wdata = '0;
    logic vec_req = 1'b0, rst_req = 1'b0;
    logic [1:0] rst_src = '0;
    logic [15:0] vec_addr;
    logic vec_valid, irq_pend, wake;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.NUM_I(NI)) dut (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_mask(i_mask),
        .x_req(x_req), .x_mask(x_mask), .swi_req(swi_req), .trap_req(trap_req),
        .stop_mode(stop_mode), .wait_mode(wait_mode), .freeze(freeze),
        .base_wr(base_wr), .base_wdata(base_wdata), .vec_req(vec_req),
        .rst_req(rst_req), .rst_src(rst_src), .vec_addr(vec_addr),
        .vec_valid(vec_valid), .irq_pend(irq_pend), .wake(wake)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [7:0] b);
        logic [7:0] lo;
        lo = 8'h80;
        if (trap_req) lo = 8'hF8;
        else if (swi_req) lo = 8'hF6;
        else if (x_req && !x_mask) lo = 8'hF4;
        else if (!i_mask && i_req != 0) begin
            for (int k = NI - 1; k >= 0; k--)
                if (i_req[k]) lo = 8'hF2 - 8'(2 * k);
        end
        return {b, lo};
    endfunction

    task automatic write_base(input logic [7:0] v);
        @(negedge clk); base_wr = 1'b1; base_wdata = v;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic fetch(input logic [15:0] exp, input string tag);
        @(negedge clk); vec_req = 1'b1;
        @(negedge clk); vec_req = 1'b0;
        chk({15'd0, vec_valid}, 16'd1, {tag, " valid R6"});
        chk(vec_addr, exp, tag);
        @(negedge clk);
        chk({vec_valid, vec_addr[14:0]}, 16'd0, "idle after fetch R6");
    endtask

    task automatic clear_all();
        i_req = '0; i_mask = 0; x_req = 0; x_mask = 0; swi_req = 0; trap_req = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] bases [4] = '{8'hFF, 8'h00, 8'h12, 8'hA5};
        repeat (3) @(negedge clk);
        chk({vec_valid, irq_pend, wake}, 16'd0, "reset outputs R6");
        chk(vec_addr, 16'h0000, "reset addr R6");
        rst_n = 1'b1;
        fetch(16'hFF80, "reset base spurious R1 R5");

        foreach (bases[b]) begin
            write_base(bases[b]);
            for (int k = 0; k < NI; k++) begin
                i_req = NI'(1) << k;
                fetch(model(bases[b]), "single source R1 R2");
            end
        end

        write_base(8'h40);
        for (int j = 0; j < NI; j++)
            for (int k = j + 1; k < NI; k++) begin
                i_req = (NI'(1) << j) | (NI'(1) << k);
                fetch({8'h40, 8'hF2 - 8'(2 * j)}, "pair lowest index R2");
            end

        for (int m = 0; m < 16; m++) begin
            trap_req = m[3]; swi_req = m[2]; x_req = m[1];
            i_req = m[0] ? 8'h24 : 8'h00;
            fetch(model(8'h40), "class priority R3");
        end
        clear_all();

        for (int m = 0; m < 64; m++) begin
            i_mask = m[0]; x_mask = m[1]; x_req = m[2]; swi_req = m[3];
            trap_req = m[4]; i_req = m[5] ? 8'h81 : 8'h00;
            #1;
            chk({15'd0, irq_pend}, {15'd0, (m[4] | m[3] | (m[2] & ~m[1]) | (m[5] & ~m[0]))},
                "pending R9");
            fetch(model(8'h40), "masking R4");
        end
        clear_all();

        i_mask = 1; i_req = 8'h10;
        fetch(16'h4080, "masked I spurious R5");
        i_mask = 0;
        fetch(16'h40EA, "nested after unmask R4");
        clear_all();

        for (int s = 0; s < 4; s++) begin
            freeze = s[0]; trap_req = 1;
            @(negedge clk); rst_src = 2'(s); rst_req = 1'b1; vec_req = 1'b1;
            @(negedge clk); rst_req = 1'b0; vec_req = 1'b0;
            chk(vec_addr, (s == 1) ? 16'hFFFC : (s == 2) ? 16'hFFFA : 16'hFFFE,
                "reset vector R7");
        end
        clear_all(); freeze = 0;

        write_base(8'h33);
        trap_req = 1; freeze = 1;
        fetch(16'hFFF8, "freeze base R8");
        write_base(8'h35);
        fetch(16'hFFF8, "freeze with write R8");
        freeze = 0;
        fetch(16'h35F8, "programmed base returns R8");
        clear_all();

        for (int m = 0; m < 64; m++) begin
            stop_mode = m[0]; wait_mode = m[1]; x_req = m[2];
            i_req = m[3] ? 8'h02 : 8'h00; swi_req = m[4]; trap_req = m[5];
            #1;
            chk({15'd0, wake}, {15'd0, ((m[0] | m[1]) & (m[2] | m[3]))}, "wake R10");
            #1;
        end
        stop_mode = 1; i_mask = 1; x_mask = 1; x_req = 1; i_req = 8'hFF;
        #1;
        chk({15'd0, wake}, 16'd0, "masked no wake R10");
        clear_all(); stop_mode = 0;

        @(negedge clk); i_req = 8'h08; vec_req = 1'b1;
        @(negedge clk); vec_req = 1'b0; i_req = 8'h01; trap_req = 1;
        #1;
        chk(vec_addr, 16'h35EC, "vector held R11");
        clear_all();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule